// File: doc/BRIEF.md
# Dual-Resolution System Time Counter

This block keeps a free-running 34-bit time count that advances by one on every cycle in which the 250 ns tick strobe is high and the count is enabled. Software sees the count through two 32-bit windows of the same register: a fine window with one step per 250 ns, and a coarse window with one step per microsecond, made by dropping the two lowest bits.

A 16-bit select mask picks any of the low count bits. The forwarded time output is the OR of the picked bits, so a single selected bit yields a square wave at that bit's period. A wrap of the full 34-bit count from all ones to zero raises a one-cycle overflow pulse that an interrupt controller can take as its overflow event.

While counting is off, software may preset the count through either window. The register port is a simple single-cycle write strobe with a combinational read. Its word addresses are control 0, status 1, fine window 2, coarse window 3 and select mask 4.

Top module: `systime_base`

## Requirements
- R1: After reset the count, the enable bit, the status bit and the select mask are all 0, and `time_bit` and `ovf_pulse` are low.
- R2: While the enable bit is 1, the count increases by exactly one (modulo 2^34) at each clock edge where `tick_en` is high, and holds otherwise. While the enable bit is 0, the count holds unless it is loaded.
- R3: A read of address 2 returns count bits 31..0.
- R4: A read of address 3 returns count bits 33..2.
- R5: With the enable bit 0, a write to address 2 loads count bits 31..0 from the write data and clears bits 33..32. The new value is visible from the next cycle.
- R6: With the enable bit 0, a write to address 3 loads count bits 33..2 from the write data and clears bits 1..0.
- R7: With the enable bit 1, writes to address 2 or address 3 leave the count unchanged apart from normal ticking.
- R8: Address 4 holds a 16-bit select mask, read back zero-extended. `time_bit` equals the OR over i of (count bit i AND mask bit i) for i in 0..15, in the same cycle. It is 0 when the mask is 0.
- R9: `ovf_pulse` is high for exactly one cycle: the cycle right after the edge at which the count stepped from all ones to zero. It is never high otherwise.
- R10: Status bit 0 (address 1) becomes 1 after the first counted tick following an enable. It returns to 0 in the cycle after the enable bit is written to 0.
- R11: Control bit 0 (address 0) is the enable bit and reads back as written. Addresses 5 to 7 read as 0, and all unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe marking each 250 ns time step |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| time_bit | output | 1 | OR of the mask-selected low count bits |
| ovf_pulse | output | 1 | One-cycle pulse after a full-count wrap |

## Verification
A count that skipped, repeated or mis-loaded a step would show on the fine window at the very next read. It would also show on `time_bit` within one cycle whenever the mask picks bit 0. An error in only the top two bits stays hidden in the fine window and appears only through the coarse window. For that reason the bench reads both windows after every preset and across the wrap. A lost or doubled overflow pulse, or one placed wrongly against the wrap, is compared in the exact cycle after the wrapping tick. A stale status bit is caught on the first read after an enable change.

// File: rtl/systime_pkg.sv
package systime_pkg;

   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_CTRL   = 3'd0,
      RA_STAT   = 3'd1,
      RA_FINE   = 3'd2,
      RA_COARSE = 3'd3,
      RA_SEL    = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      LD_NONE   = 2'd0,
      LD_FINE   = 2'd1,
      LD_COARSE = 2'd2
   } load_kind_e;

endpackage

// File: rtl/systime_counter.sv
module systime_counter
   import systime_pkg::*;
#(
   parameter int CNT_W  = 34,
   parameter int VIEW_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   input  logic              tick,
   input  load_kind_e        ld_kind,
   input  logic [VIEW_W-1:0] ld_val,
   output logic [CNT_W-1:0]  cnt,
   output logic              ovf
);

   localparam int              SHIFT    = CNT_W - VIEW_W;
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] ALL_ONE = '1;

   initial begin
      if (SHIFT < 1) $fatal(1, "systime_counter: CNT_W must exceed VIEW_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         ovf <= 1'b0;
         if (count_en && tick) begin
            cnt <= cnt + ONE;
            ovf <= (cnt == ALL_ONE);
         end else if (!count_en) begin
            case (ld_kind)
               LD_FINE:   cnt <= {{SHIFT{1'b0}}, ld_val};
               LD_COARSE: cnt <= {ld_val, {SHIFT{1'b0}}};
               default:   cnt <= cnt;
            endcase
         end
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && ld_kind == LD_NONE) |=> $stable(cnt)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && tick) |=> (cnt == $past(cnt) + ONE)); // R2
   AST_LOCKED_VIEWS: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !tick) |=> $stable(cnt)); // R7
   AST_FINE_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && ld_kind == LD_FINE) |=> (cnt[CNT_W-1:VIEW_W] == '0)); // R5
   AST_COARSE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && ld_kind == LD_COARSE) |=> (cnt[SHIFT-1:0] == '0)); // R6
   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> !ovf); // R9
   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (cnt == '0)); // R9

endmodule

// File: rtl/systime_bitsel.sv
module systime_bitsel #(
   parameter int SEL_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] cnt_low,
   input  logic [SEL_W-1:0] mask,
   output logic             bit_o
);

   logic [SEL_W-1:0] picked;

   initial begin
      if (SEL_W < 1) $fatal(1, "systime_bitsel: SEL_W must be at least 1");
   end

   for (genvar i = 0; i < SEL_W; i++) begin : g_pick
      assign picked[i] = cnt_low[i] & mask[i];
   end

   if (REG_OUT) begin : g_flop
      always_ff @(posedge clk) begin
         if (!rst_n) bit_o <= 1'b0;
         else        bit_o <= |picked;
      end
      AST_NO_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(mask) == '0) |-> !bit_o); // R8
   end else begin : g_comb
      assign bit_o = |picked;
      AST_NO_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mask == '0) |-> !bit_o); // R8
   end

endmodule

// File: rtl/systime_regs.sv
module systime_regs
   import systime_pkg::*;
#(
   parameter int CNT_W  = 34,
   parameter int VIEW_W = 32,
   parameter int SEL_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [VIEW_W-1:0]     wdata,
   input  logic [CNT_W-1:0]      cnt,
   output logic [VIEW_W-1:0]     rdata,
   output logic                  count_en,
   output logic [SEL_W-1:0]      sel_mask,
   output load_kind_e            ld_kind,
   output logic [VIEW_W-1:0]     ld_val
);

   localparam int SHIFT = CNT_W - VIEW_W;

   initial begin
      if (SEL_W > VIEW_W) $fatal(1, "systime_regs: mask wider than a register");
   end

   logic en_q, en_d, run_q, run_d;
   logic [SEL_W-1:0] mask_q;
   reg_addr_e a;

   assign a = reg_addr_e'(addr);

   always_comb begin
      en_d  = (wr_en && a == RA_CTRL) ? wdata[0] : en_q;
      run_d = en_d && (run_q || (en_q && tick));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         run_q  <= 1'b0;
         mask_q <= '0;
      end else begin
         en_q  <= en_d;
         run_q <= run_d;
         if (wr_en && a == RA_SEL) mask_q <= wdata[SEL_W-1:0];
      end
   end

   always_comb begin
      ld_kind = LD_NONE;
      if (wr_en && a == RA_FINE)   ld_kind = LD_FINE;
      if (wr_en && a == RA_COARSE) ld_kind = LD_COARSE;
   end

   assign ld_val   = wdata;
   assign count_en = en_q;
   assign sel_mask = mask_q;

   always_comb begin
      rdata = '0;
      case (a)
         RA_CTRL:   rdata[0] = en_q;
         RA_STAT:   rdata[0] = run_q;
         RA_FINE:   rdata = cnt[VIEW_W-1:0];
         RA_COARSE: rdata = cnt[CNT_W-1:SHIFT];
         RA_SEL:    rdata[SEL_W-1:0] = mask_q;
         default:   rdata = '0;
      endcase
   end

   AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> en_q); // R10
   AST_RUN_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> ($past(tick) && $past(en_q))); // R10
   AST_CTRL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a == RA_CTRL) |=> (en_q == $past(wdata[0]))); // R11

endmodule

// File: rtl/systime_base.sv
module systime_base
   import systime_pkg::*;
#(
   parameter int CNT_W       = 34,
   parameter int VIEW_W      = 32,
   parameter int SEL_W       = 16,
   parameter bit REG_TIMEBIT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic                  reg_wr,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [VIEW_W-1:0]     reg_wdata,
   output logic [VIEW_W-1:0]     reg_rdata,
   output logic                  time_bit,
   output logic                  ovf_pulse
);

   initial begin
      if (SEL_W > CNT_W) $fatal(1, "systime_base: SEL_W exceeds CNT_W");
   end

   logic [CNT_W-1:0]  cnt;
   logic              count_en;
   logic [SEL_W-1:0]  sel_mask;
   load_kind_e        ld_kind;
   logic [VIEW_W-1:0] ld_val;

   systime_regs #(.CNT_W(CNT_W), .VIEW_W(VIEW_W), .SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .cnt      (cnt),
      .rdata    (reg_rdata),
      .count_en (count_en),
      .sel_mask (sel_mask),
      .ld_kind  (ld_kind),
      .ld_val   (ld_val)
   );

   systime_counter #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (count_en),
      .tick     (tick_en),
      .ld_kind  (ld_kind),
      .ld_val   (ld_val),
      .cnt      (cnt),
      .ovf      (ovf_pulse)
   );

   systime_bitsel #(.SEL_W(SEL_W), .REG_OUT(REG_TIMEBIT)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_low (cnt[SEL_W-1:0]),
      .mask    (sel_mask),
      .bit_o   (time_bit)
   );

   AST_OVF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> ($past(count_en) && $past(tick_en))); // R9

endmodule

// File: tb/systime_base_bench.sv
`timescale 1ns/1ps
module systime_base_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        time_bit;
   logic        ovf_pulse;

   int vectors = 0;
   int fails = 0;

   logic [33:0] m_cnt = '0;
   logic        m_en = 1'b0, m_run = 1'b0, m_ovf = 1'b0;
   logic [15:0] m_mask = '0;

   always #2 clk = ~clk;

   systime_base u_systime_base (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .time_bit(time_bit), .ovf_pulse(ovf_pulse)
   );

   function automatic logic [31:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0: return {31'd0, m_en};
         3'd1: return {31'd0, m_run};
         3'd2: return m_cnt[31:0];
         3'd3: return m_cnt[33:2];
         3'd4: return {16'd0, m_mask};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R11";
         3'd1: return "R10";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_edge(input logic tk, input logic wr, input logic [2:0] a,
                             input logic [31:0] d);
      logic en_n;
      en_n = (wr && a == 3'd0) ? d[0] : m_en;
      m_run = en_n && (m_run || (m_en && tk));
      m_ovf = 1'b0;
      if (m_en && tk) begin
         m_ovf = (m_cnt == '1);
         m_cnt = m_cnt + 34'd1;
      end else if (!m_en && wr && a == 3'd2) begin
         m_cnt = {2'b00, d};
      end else if (!m_en && wr && a == 3'd3) begin
         m_cnt = {d, 2'b00};
      end
      if (wr && a == 3'd4) m_mask = d[15:0];
      m_en = en_n;
   endtask

   // one clock: drive, check current state, then advance the model
   task automatic cyc(input logic tk, input logic wr, input logic [2:0] a,
                      input logic [31:0] d, input string tag);
      @(negedge clk);
      tick_en = tk; reg_wr = wr; reg_addr = a; reg_wdata = d;
      #1;
      chk((tag == "") ? tag_of(a) : tag, 34'(reg_rdata), 34'(exp_read(a)));
      chk("R8", 34'(time_bit), 34'(|(m_cnt[15:0] & m_mask)));
      chk("R9", 34'(ovf_pulse), 34'(m_ovf));
      @(posedge clk);
      model_edge(tk, wr, a, d);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20250611));
      // R1: reset state
      repeat (3) @(posedge clk);
      for (int a = 0; a < 5; a++) begin
         @(negedge clk); reg_addr = 3'(a); #1;
         chk("R1", 34'(reg_rdata), 34'd0);
      end
      chk("R1", 34'(time_bit), 34'd0);
      chk("R1", 34'(ovf_pulse), 34'd0);
      @(negedge clk); rst_n = 1'b1;

      // R2: disabled ticks do nothing
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 3'd2, 32'd0, "R2");
      // R5: preset fine window, top bits cleared
      cyc(1'b0, 1'b1, 3'd2, 32'hDEAD_BEEF, "");
      cyc(1'b0, 1'b0, 3'd2, 32'd0, "R5");
      cyc(1'b0, 1'b0, 3'd3, 32'd0, "R5");
      // R6: preset coarse window, low bits cleared
      cyc(1'b0, 1'b1, 3'd3, 32'h1234_5679, "");
      cyc(1'b0, 1'b0, 3'd2, 32'd0, "R6");
      cyc(1'b0, 1'b0, 3'd3, 32'd0, "R6");
      // R10/R2: enable, status waits for a counted tick
      cyc(1'b0, 1'b1, 3'd0, 32'd1, "R11");
      cyc(1'b0, 1'b0, 3'd1, 32'd0, "R10");
      cyc(1'b1, 1'b0, 3'd1, 32'd0, "R10");
      cyc(1'b0, 1'b0, 3'd1, 32'd0, "R10");
      for (int i = 0; i < 6; i++) cyc(1'(i % 2), 1'b0, 3'd2, 32'd0, "R2");
      // R7: writes to views while enabled ignored
      cyc(1'b1, 1'b1, 3'd2, 32'h0000_0000, "");
      cyc(1'b0, 1'b1, 3'd3, 32'hFFFF_0000, "");
      cyc(1'b0, 1'b0, 3'd2, 32'd0, "R7");
      cyc(1'b0, 1'b0, 3'd3, 32'd0, "R7");
      // R8: empty mask, then bit 0 and bit 15
      cyc(1'b1, 1'b1, 3'd4, 32'h0000_0000, "");
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 3'd4, 32'd0, "R8");
      cyc(1'b1, 1'b1, 3'd4, 32'hFFFF_0001, "");
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 3'd4, 32'd0, "R8");
      cyc(1'b1, 1'b1, 3'd4, 32'h0000_8000, "");
      // R10: disable clears status
      cyc(1'b1, 1'b1, 3'd0, 32'd0, "R11");
      cyc(1'b1, 1'b0, 3'd1, 32'd0, "R10");
      // R9: wrap of full count
      cyc(1'b0, 1'b1, 3'd3, 32'hFFFF_FFFF, "");
      cyc(1'b0, 1'b1, 3'd0, 32'd1, "R11");
      for (int i = 0; i < 8; i++) cyc(1'(i != 2), 1'b0, 3'd3, 32'd0, "R9");
      // R11: unused addresses
      for (int a = 5; a < 8; a++) cyc(1'b1, 1'b0, 3'(a), 32'd0, "R11");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic tk, wr;
         logic [2:0] a;
         tk = ($urandom % 4) != 0;
         wr = ($urandom % 8) == 0;
         a  = 3'($urandom % 8);
         r  = $urandom;
         if (wr && a == 3'd0) r[0] = ($urandom % 4) != 0;
         if (wr && (a == 3'd2 || a == 3'd3) && ($urandom % 4) == 0) r = 32'hFFFF_FFFF;
         if (wr && a == 3'd4 && ($urandom % 3) == 0) r = 32'(1) << ($urandom % 16);
         cyc(tk, wr, a, r, "");
      end
      summary();
   end

endmodule